// File: doc/BRIEF.md
# Registered Operand Shifter With Carry Flag

This block shifts or rotates a 32-bit data word by a variable amount and reports the bit that leaves the word as a carry flag. It serves as the second-operand stage of a processor datapath: the caller presents a word, a 3-bit shift kind, a shift count and the current carry flag, and one clock later receives the shifted word and the new carry. The count may come from an immediate field or from a full register, so counts of zero, of exactly the word width and beyond the word width each follow their own rules.

The block has three parts. A classifier sorts the low count byte into one of four classes: none (0), partial (1 to 31), full (exactly 32) and over (above 32). It also reduces the count modulo 32. A combinational core forms the result and the carry for the selected kind. An output stage registers both values and runs a two-state machine. The state `ST_IDLE` means no fresh result is held. The state `ST_HOLD` means the registers hold a result captured on the previous edge. The transition *capture* (any state to `ST_HOLD`) is taken when `in_valid` is high. The transition *drain* (any state to `ST_IDLE`) is taken when it is low. `out_valid` is high exactly in `ST_HOLD`.

Top module: `opshift_top`

## Requirements
- R1: After reset `out_valid` is 0 and `result`/`carry_out` are 0. `out_valid` is high in the cycle after each cycle with `in_valid` high, and low in the cycle after each cycle with `in_valid` low.
- R2: Shift kind codes are 0 = logical left, 1 = logical right, 2 = arithmetic right, 3 = rotate right, 4 = rotate right by one through carry. Only `amount[7:0]` is used; bits 31:8 have no effect on the result or the carry.
- R3: For kinds 0 to 3 with a count of zero, `result` equals the operand and `carry_out` equals `carry_in`.
- R4: Logical left by n (1 to 32) gives operand shifted left by n with zeros filled in, and carry equal to operand bit 32-n. For n = 32 this means a zero result with carry equal to bit 0.
- R5: Logical right by n (1 to 32) gives operand shifted right with zeros filled in, and carry equal to operand bit n-1. For n = 32 this means a zero result with carry equal to bit 31.
- R6: Arithmetic right by n (1 to 32) fills the vacated top bits with operand bit 31, and the carry equals operand bit n-1.
- R7: Logical left or logical right by more than 32 gives a zero result and a zero carry.
- R8: Arithmetic right by more than 32 sets every result bit and the carry to operand bit 31.
- R9: Rotate right by a nonzero count rotates by the count modulo 32, and the carry equals bit 31 of the result. A count that is a nonzero multiple of 32 returns the operand unchanged with carry equal to its bit 31.
- R10: Kind 4 gives {carry_in, operand[31:1]} with carry equal to operand bit 0, whatever the count holds.
- R11: Kind codes 5 to 7 return the operand unchanged with `carry_out` equal to `carry_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| operand | input | 32 | Word to shift |
| kind | input | 3 | Shift kind code |
| amount | input | 32 | Shift count; only bits 7:0 are used |
| carry_in | input | 1 | Current carry flag |
| out_valid | output | 1 | Result registers hold a fresh result |
| result | output | 32 | Shifted word |
| carry_out | output | 1 | New carry flag |

## Verification
Every result, its carry and its valid flag are due exactly one rising edge after the request is presented. Nothing else in the block adds a cycle. The bench drives each request on a falling edge and compares the outputs on the next falling edge. It uses expected values from a 64-bit reference function written from the requirements. The embedded properties use the same one-cycle offset, through `|=>` and `$past` of depth one. An idle cycle is checked the same way, for a low `out_valid` one cycle later.

// File: rtl/opshift_pkg.sv
package opshift_pkg;

    typedef enum logic [2:0] {
        SK_LSL = 3'd0,
        SK_LSR = 3'd1,
        SK_ASR = 3'd2,
        SK_ROR = 3'd3,
        SK_RRX = 3'd4
    } shift_kind_e;

    typedef enum logic [1:0] {
        CNT_NONE,
        CNT_PART,
        CNT_FULL,
        CNT_OVER
    } cnt_class_e;

    typedef enum logic {
        ST_IDLE,
        ST_HOLD
    } out_state_e;

endpackage

// File: rtl/opshift_count_class.sv
module opshift_count_class
    import opshift_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic [CNT_W-1:0] cnt,
    output cnt_class_e       cls,
    output logic [IDX_W-1:0] cnt_mod
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DATA_W);

    always_comb begin
        if (cnt == '0)
            cls = CNT_NONE;
        else if (cnt < FULL_CNT)
            cls = CNT_PART;
        else if (cnt == FULL_CNT)
            cls = CNT_FULL;
        else
            cls = CNT_OVER;
    end

    assign cnt_mod = cnt[IDX_W-1:0];

endmodule

// File: rtl/opshift_core.sv
module opshift_core
    import opshift_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic [2:0]        kind,
    input  logic [DATA_W-1:0] opnd,
    input  logic              cin,
    input  cnt_class_e        cls,
    input  logic [IDX_W-1:0]  cnt_mod,
    output logic [DATA_W-1:0] res,
    output logic              cout
);

    logic [IDX_W-1:0]    idx_lo;
    logic [IDX_W-1:0]    idx_hi;
    logic [DATA_W-1:0]   asr_v;
    logic [2*DATA_W-1:0] dbl_v;
    logic [DATA_W-1:0]   ror_v;
    logic                sign_b;

    assign idx_lo = cnt_mod - 1'b1;
    assign idx_hi = (~cnt_mod) + 1'b1;
    assign asr_v  = DATA_W'($signed(opnd) >>> cnt_mod);
    assign dbl_v  = {opnd, opnd} >> cnt_mod;
    assign ror_v  = dbl_v[DATA_W-1:0];
    assign sign_b = opnd[DATA_W-1];

    always_comb begin
        res  = opnd;
        cout = cin;
        case (kind)
            SK_LSL: begin
                unique case (cls)
                    CNT_NONE: ;
                    CNT_PART: begin res = opnd << cnt_mod; cout = opnd[idx_hi]; end
                    CNT_FULL: begin res = '0; cout = opnd[0]; end
                    CNT_OVER: begin res = '0; cout = 1'b0; end
                endcase
            end
            SK_LSR: begin
                unique case (cls)
                    CNT_NONE: ;
                    CNT_PART: begin res = opnd >> cnt_mod; cout = opnd[idx_lo]; end
                    CNT_FULL: begin res = '0; cout = sign_b; end
                    CNT_OVER: begin res = '0; cout = 1'b0; end
                endcase
            end
            SK_ASR: begin
                unique case (cls)
                    CNT_NONE: ;
                    CNT_PART: begin res = asr_v; cout = opnd[idx_lo]; end
                    CNT_FULL,
                    CNT_OVER: begin res = {DATA_W{sign_b}}; cout = sign_b; end
                endcase
            end
            SK_ROR: begin
                if (cls != CNT_NONE) begin
                    res  = ror_v;
                    cout = ror_v[DATA_W-1];
                end
            end
            SK_RRX: begin
                res  = {cin, opnd[DATA_W-1:1]};
                cout = opnd[0];
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/opshift_top.sv
module opshift_top
    import opshift_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int AMT_IN_W = 32,
    parameter int CNT_W    = 8,
    localparam int IDX_W   = $clog2(DATA_W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [DATA_W-1:0]   operand,
    input  logic [2:0]          kind,
    input  logic [AMT_IN_W-1:0] amount,
    input  logic                carry_in,
    output logic                out_valid,
    output logic [DATA_W-1:0]   result,
    output logic                carry_out
);

    logic [CNT_W-1:0]  cnt;
    logic              amt_unused_bits;
    cnt_class_e        cls;
    logic [IDX_W-1:0]  cnt_mod;
    logic [DATA_W-1:0] res_c;
    logic              cout_c;
    out_state_e        state_q, state_d;

    assign cnt             = amount[CNT_W-1:0];
    assign amt_unused_bits = ^amount[AMT_IN_W-1:CNT_W];

    opshift_count_class #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_class (
        .cnt     (cnt),
        .cls     (cls),
        .cnt_mod (cnt_mod)
    );

    opshift_core #(.DATA_W(DATA_W)) u_core (
        .kind    (kind),
        .opnd    (operand),
        .cin     (carry_in),
        .cls     (cls),
        .cnt_mod (cnt_mod),
        .res     (res_c),
        .cout    (cout_c)
    );

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_HOLD : ST_IDLE;
            ST_HOLD: state_d = in_valid ? ST_HOLD : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result    <= '0;
            carry_out <= 1'b0;
        end else if (in_valid) begin
            result    <= res_c;
            carry_out <= cout_c;
        end
    end

    assign out_valid = (state_q == ST_HOLD);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R1
    AST_ZERO_COUNT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cnt == '0 && kind != SK_RRX) |=>
        (result == $past(operand) && carry_out == $past(carry_in))); // R3
    AST_LOGICAL_OVER: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (kind == SK_LSL || kind == SK_LSR) && cnt > CNT_W'(DATA_W)) |=>
        (result == '0 && !carry_out)); // R7
    AST_ARITH_OVER: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && kind == SK_ASR && cnt > CNT_W'(DATA_W)) |=>
        (result == {DATA_W{$past(operand[DATA_W-1])}} &&
         carry_out == $past(operand[DATA_W-1]))); // R8
    AST_RRX_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && kind == SK_RRX) |=>
        (result == {$past(carry_in), $past(operand[DATA_W-1:1])} &&
         carry_out == $past(operand[0]))); // R10

endmodule

// File: tb/opshift_top_test.sv
`timescale 1ns/1ps
module opshift_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] operand = '0;
    logic [2:0]  kind = '0;
    logic [31:0] amount = '0;
    logic        carry_in = 1'b0;
    logic        out_valid;
    logic [31:0] result;
    logic        carry_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    opshift_top uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
        .kind(kind), .amount(amount), .carry_in(carry_in),
        .out_valid(out_valid), .result(result), .carry_out(carry_out)
    );

    function automatic logic [32:0] ref_model(input logic [2:0] k, input logic [31:0] op,
                                              input logic [7:0] n, input logic ci);
        logic [63:0] w;
        int sh;
        ref_model = {ci, op};
        case (k)
            3'd0: if (n != 0) begin
                if (n > 32) ref_model = 33'd0;
                else begin w = {32'd0, op} << n; ref_model = {w[32], w[31:0]}; end
            end
            3'd1: if (n != 0) begin
                if (n > 32) ref_model = 33'd0;
                else begin w = {op, 32'd0} >> n; ref_model = {w[31], w[63:32]}; end
            end
            3'd2: if (n != 0) begin
                sh = (n > 32) ? 32 : int'(n);
                w = 64'($signed({op, 32'd0}) >>> sh);
                ref_model = {w[31], w[63:32]};
            end
            3'd3: if (n != 0) begin
                sh = int'(n) % 32;
                w = {op, op} >> sh;
                ref_model = {w[31], w[31:0]};
            end
            3'd4: ref_model = {op[0], ci, op[31:1]};
            default: ;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] k, input logic [7:0] n);
        if (k > 3'd4) return "R11";
        if (k == 3'd4) return "R10";
        if (k == 3'd3) return "R9";
        if (n == 0) return "R3";
        if (k == 3'd2) return (n > 32) ? "R8" : "R6";
        if (n > 32) return "R7";
        return (k == 3'd0) ? "R4" : "R5";
    endfunction

    task automatic check_bit(input string tg, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b", tg, what, act, exp);
        end
    endtask

    task automatic check_word(input string tg, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%08h expected=%08h", tg, what, act, exp);
        end
    endtask

    task automatic run(input logic [2:0] k, input logic [31:0] op, input logic [31:0] amt,
                       input logic ci, input string tg_in);
        logic [32:0] e;
        string tg;
        tg = (tg_in == "") ? tag_of(k, amt[7:0]) : tg_in;
        e = ref_model(k, op, amt[7:0], ci);
        in_valid = 1'b1; kind = k; operand = op; amount = amt; carry_in = ci;
        @(negedge clk);
        check_bit("R1", "out_valid", out_valid, 1'b1);
        check_word(tg, "result", result, e[31:0]);
        check_bit(tg, "carry_out", carry_out, e[32]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] hold;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check_bit("R1", "reset out_valid", out_valid, 1'b0);
        check_word("R1", "reset result", result, 32'd0);
        check_bit("R1", "reset carry", carry_out, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // directed corners
        run(3'd0, 32'h8000_0001, 32'd1,  1'b0, "");     // R4 carry from bit 31
        run(3'd0, 32'h0000_0001, 32'd32, 1'b0, "");     // R4 exact width
        run(3'd0, 32'hFFFF_FFFF, 32'd33, 1'b1, "");     // R7
        run(3'd1, 32'h8000_0000, 32'd32, 1'b0, "");     // R5 exact width
        run(3'd1, 32'h0000_0003, 32'd2,  1'b0, "");     // R5
        run(3'd1, 32'hFFFF_FFFF, 32'd200,1'b1, "");     // R7
        run(3'd2, 32'h8000_0010, 32'd5,  1'b0, "");     // R6 sign fill
        run(3'd2, 32'h7000_0000, 32'd32, 1'b1, "");     // R6 exact width positive
        run(3'd2, 32'h8000_0000, 32'd40, 1'b0, "");     // R8
        run(3'd3, 32'h0000_0001, 32'd1,  1'b0, "");     // R9
        run(3'd3, 32'h8765_4321, 32'd64, 1'b0, "");     // R9 multiple of width
        run(3'd3, 32'h1234_5678, 32'd0,  1'b1, "R3");   // R3 rotate by zero
        run(3'd4, 32'h0000_0001, 32'd17, 1'b1, "");     // R10 count ignored
        run(3'd6, 32'hCAFE_F00D, 32'd9,  1'b1, "");     // R11
        run(3'd7, 32'h0000_0001, 32'd0,  1'b0, "");     // R11
        run(3'd0, 32'h0000_0001, 32'hABCD_0120, 1'b0, "R2"); // R2 low byte 32
        run(3'd1, 32'hDEAD_BEEF, 32'hFFFF_FF00, 1'b1, "R2"); // R2 low byte 0

        // idle cycle: valid drops, result holds
        hold = result;
        in_valid = 1'b0;
        operand = 32'h5555_5555;
        @(negedge clk);
        check_bit("R1", "idle out_valid", out_valid, 1'b0);
        check_word("R1", "idle hold", result, hold);

        // constrained random
        for (int i = 0; i < 600; i++) begin
            logic [2:0]  k;
            logic [31:0] a;
            int sel;
            k = 3'($urandom % 8);
            sel = $urandom % 4;
            case (sel)
                0: a = {$urandom, 8'd0} | 32'($urandom % 33);
                1: a = 32'd32;
                2: a = $urandom;
                default: a = 32'($urandom % 3) * 32'd32;
            endcase
            run(k, $urandom, a, 1'($urandom), "");
            if ((i % 50) == 49) begin
                in_valid = 1'b0;
                @(negedge clk);
                check_bit("R1", "gap out_valid", out_valid, 1'b0);
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule